// File: doc/BRIEF.md
# Keyboard Receive Port

This block sits on a 16-bit processor bus as a small memory-mapped input device. A keyboard source presents an 8-bit character code together with a one-cycle strobe; the port latches the code into a data register and raises a ready flag. Software either polls the flag through the status register or enables an interrupt request, then reads the data register, which hands the character over and frees the port for the next keystroke.

While a character has not yet been read, the port refuses further keystrokes so that the held code is never overwritten. The only software-writable state is the interrupt-enable bit. Reset is asynchronous and active-low at the pin, and its release is synchronized to the clock inside the block.

Top module: `kbd_port`

## Requirements
- R1: A read of the data register returns the held character code in bits 7:0 and zero in bits 15:8.
- R2: A key strobe while the ready flag is 0 stores the code and sets the ready flag at the next clock edge.
- R3: A key strobe while the ready flag is 1 (and no data-register read in the same cycle) is discarded: the held code and the ready flag are unchanged.
- R4: A bus read of the data register clears the ready flag at the next clock edge, after which a new key strobe is accepted.
- R5: A bus write to the status register loads wdata bit 14 into the interrupt-enable bit.
- R6: The irq output is 1 exactly when the ready flag and the interrupt-enable bit are both 1.
- R7: The status register answers at address 0xFE00 and the data register at 0xFE02; an access to any other address, or no access, reads as zero and changes no state.
- R8: A status read returns ready in bit 15, interrupt-enable in bit 14 and zero in all other bits; bus writes to status bit 15 and to the data register have no effect.
- R9: A key strobe in the same cycle as a data-register read is accepted: the read returns the old code, and afterwards the ready flag stays 1 and the data register holds the new code.
- R10: While reset is asserted and after its release, the ready flag, the interrupt-enable bit and the data register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe: a character is present on key_code |
| key_code | input | 8 | Character code from the keyboard source |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, combinational for the current access |
| key_ready | output | 1 | Ready flag: an unread character is held |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a keystroke landing in exactly the cycle in which software reads the data register, since the two come from independent sources and the lockout rule would discard it one cycle earlier. The bench drives a bus read of the data register and a key strobe from the same negative clock edge, expects the old code on the bus in that cycle, and then reads again to find the new code with the flag still set. Lockout is reached the same way in reverse: a second strobe is sent while the first character is still unread, and the following read must return the first code.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int BUS_W   = 16;
  localparam int CHAR_W  = 8;
  localparam int RDY_BIT = 15;
  localparam int IEN_BIT = 14;
  localparam logic [BUS_W-1:0] STAT_ADDR = 16'hFE00;
  localparam logic [BUS_W-1:0] DATA_ADDR = 16'hFE02;

  typedef struct packed {
    logic stat_rd;
    logic stat_wr;
    logic data_rd;
    logic data_wr;
  } kbd_acc_t;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_A = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_A = 16'hFE02
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output kbd_pkg::kbd_acc_t acc
);
  logic hit_stat, hit_data;

  always_comb begin
    hit_stat    = sel && (addr == STAT_A);
    hit_data    = sel && (addr == DATA_A);
    acc.stat_rd = hit_stat && !we;
    acc.stat_wr = hit_stat &&  we;
    acc.data_rd = hit_data && !we;
    acc.data_wr = hit_data &&  we;
  end
endmodule

// File: rtl/kbd_status.sv
module kbd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic key_valid,
  input  logic data_rd,
  input  logic stat_wr,
  input  logic ien_wbit,
  output logic ready_q,
  output logic ien_q,
  output logic capture
);
  logic ready_d, ien_d;

  always_comb begin
    capture = key_valid && (!ready_q || data_rd);
    ready_d = ready_q;
    if (data_rd) ready_d = 1'b0;
    if (capture) ready_d = 1'b1;
    ien_d = ien_q;
    if (stat_wr) ien_d = ien_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      ien_q   <= ien_d;
    end
  end
endmodule

// File: rtl/kbd_data.sv
module kbd_data #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CHAR_W-1:0] code_in,
  output logic [CHAR_W-1:0] data_q
);
  logic [CHAR_W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (capture) data_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (capture) data_q <= data_d;
  end
endmodule

// File: rtl/kbd_port.sv
module kbd_port
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              key_ready,
  output logic              irq
);
  localparam int PAD_W = BUS_W - CHAR_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  kbd_acc_t          acc;
  logic              ien;
  logic              capture;
  logic [CHAR_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  kbd_decode #(
    .ADDR_W (BUS_W),
    .STAT_A (STAT_ADDR),
    .DATA_A (DATA_ADDR)
  ) u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .acc  (acc)
  );

  kbd_status u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .key_valid (key_valid),
    .data_rd   (acc.data_rd),
    .stat_wr   (acc.stat_wr),
    .ien_wbit  (bus_wdata[IEN_BIT]),
    .ready_q   (key_ready),
    .ien_q     (ien),
    .capture   (capture)
  );

  kbd_data #(.CHAR_W(CHAR_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (capture),
    .code_in (key_code),
    .data_q  (data_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.stat_rd) begin
      bus_rdata[RDY_BIT] = key_ready;
      bus_rdata[IEN_BIT] = ien;
    end else if (acc.data_rd) begin
      bus_rdata = {{PAD_W{1'b0}}, data_q};
    end
  end

  assign irq = key_ready & ien;
endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk
  import kbd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic [CHAR_W-1:0] key_code,
  input logic              data_rd,
  input logic              stat_wr,
  input logic              data_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              key_ready,
  input logic              ien,
  input logic              irq,
  input logic [CHAR_W-1:0] data_q
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> (bus_rdata[BUS_W-1:CHAR_W] == '0));

  assert_capture_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_ready && data_q == $past(key_code)));

  assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && key_valid && !data_rd) |=> $stable(data_q));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_valid) |=> !key_ready);

  assert_ien_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (ien == $past(bus_wdata[IEN_BIT])));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (key_ready && ien));

  assert_ready_only_by_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_ready) |-> $past(key_valid));

  assert_data_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !key_valid) |=> $stable(data_q));

  assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && key_valid) |=> (key_ready && data_q == $past(key_code)));
endmodule

bind kbd_port kbd_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .key_valid (key_valid),
  .key_code  (key_code),
  .data_rd   (acc.data_rd),
  .stat_wr   (acc.stat_wr),
  .data_wr   (acc.data_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .key_ready (key_ready),
  .ien       (ien),
  .irq       (irq),
  .data_q    (data_q)
);

// File: tb/kbd_port_test.sv
module kbd_port_test;
  localparam int P = 10;
  localparam logic [15:0] ST = 16'hFE00;
  localparam logic [15:0] DT = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_valid;
  logic [7:0]  key_code;
  logic        bus_sel, bus_we;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata;
  logic        key_ready, irq;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;
  bit   fin   = 1'b0;

  always #(P/2) clk = ~clk;

  kbd_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_code  (key_code),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .key_ready (key_ready),
    .irq       (irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = c;
    @(negedge clk);
    key_valid = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_sel  = 1'b1;
    bus_we   = 1'b0;
    bus_addr = a;
    it.val = e;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel   = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    bus_we  = 1'b0;
    #1;
  endtask

  // monitor: compares every bus read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(P/4);
      if (bus_sel && !bus_we) begin
        if (sb.size() == 0) chk(16'h1, 16'h0, "scoreboard underflow");
        else begin
          exp_t it;
          it = sb.pop_front();
          chk(bus_rdata, it.val, it.tag);
        end
      end
    end
  end

  initial begin
    #(P*20000);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_code = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk({15'd0, key_ready}, 16'd0, "R10 ready in reset");
    chk({15'd0, irq}, 16'd0, "R10 irq in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(ST, 16'h0000, "R10 status after reset");
    rd(DT, 16'h0000, "R10 data after reset");

    // basic capture and handover
    key(8'h41);
    chk({15'd0, key_ready}, 16'd1, "R2 ready after key");
    rd(ST, 16'h8000, "R8 status with ready");
    rd(DT, 16'h0041, "R1 data read");
    chk({15'd0, key_ready}, 16'd0, "R4 ready cleared by data read");

    // lockout
    key(8'h42);
    key(8'h43);
    chk({15'd0, key_ready}, 16'd1, "R3 ready held");
    rd(DT, 16'h0042, "R3 second key discarded");
    key(8'hC3);
    rd(DT, 16'h00C3, "R4 capture re-enabled, R1 high code");

    // interrupt enable
    wr(ST, 16'h4000);
    rd(ST, 16'h4000, "R5 enable set");
    chk({15'd0, irq}, 16'd0, "R6 irq low without ready");
    key(8'h55);
    chk({15'd0, irq}, 16'd1, "R6 irq high with ready and enable");
    rd(ST, 16'hC000, "R8 status both bits");
    rd(DT, 16'h0055, "R1 data with irq");
    chk({15'd0, irq}, 16'd0, "R6 irq drops after read");

    // writes to bit 15 and to data register ignored
    wr(ST, 16'hFFFF);
    chk({15'd0, key_ready}, 16'd0, "R8 write to bit 15 ignored");
    rd(ST, 16'h4000, "R8 only enable written");
    wr(DT, 16'h1234);
    key(8'h31);
    wr(DT, 16'h00EE);
    rd(DT, 16'h0031, "R8 data write ignored");

    // decode
    key(8'h7A);
    rd(16'hFE04, 16'h0000, "R7 unmapped reads zero");
    rd(16'hFE01, 16'h0000, "R7 odd address reads zero");
    wr(16'hFE04, 16'h0000);
    chk({15'd0, key_ready}, 16'd1, "R7 unmapped access leaves ready");
    chk({15'd0, irq}, 16'd1, "R7 unmapped write leaves enable");
    chk(bus_rdata, 16'h0000, "R7 idle bus reads zero");

    // disable interrupt while ready
    wr(ST, 16'h0000);
    chk({15'd0, irq}, 16'd0, "R5 R6 irq off after disable");
    rd(ST, 16'h8000, "R5 enable cleared");

    // same-cycle read and keystroke
    begin
      exp_t it;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = DT;
      key_valid = 1'b1; key_code = 8'h62;
      it.val = 16'h007A; it.tag = "R9 old code on same-cycle read";
      sb.push_back(it);
      @(negedge clk);
      bus_sel = 1'b0; key_valid = 1'b0;
      #1;
    end
    chk({15'd0, key_ready}, 16'd1, "R9 ready stays set");
    rd(DT, 16'h0062, "R9 new code captured");
    chk({15'd0, key_ready}, 16'd0, "R4 final clear");

    repeat (2) @(negedge clk);
    chk(16'(sb.size()), 16'd0, "scoreboard drained");
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule